// File: doc/BRIEF.md
# Word-to-Byte Bus Bridge

This block sits between a CPU with a 16-bit data bus and a peripheral bus that is only eight bits wide. Every word access the CPU starts is carried out as two byte accesses on the narrow bus. The byte at the odd address always goes first and the byte at the even address second. A one-byte holding latch carries data between the two halves. While the pair of byte cycles runs, the block holds the CPU's READY output low for a fixed count of clock cycles. It raises READY again when the sequence is done.

Some address ranges belong to a fast 16-bit RAM expansion. An access to one of these ranges is handed straight to the RAM port in the same cycle, as a full word with a word index. It causes no byte cycles and no wait. The CPU's bus direction line, sampled when the access starts, chooses between the read sequence and the write sequence.

The CPU presents a word address, so byte address bit 0 does not exist on this side. The block rebuilds bit 0 itself for the byte bus.

Top module: `word_byte_bridge`

## Requirements
- R1: An accepted access outside the fast ranges drives `cpu_ready` low for exactly five cycles, starting in the cycle after `cpu_start` is sampled. `cpu_ready` is high again in the sixth cycle.
- R2: The fast ranges are byte addresses 0x2000–0x3FFF, 0xA000–0xBFFF and 0xC000–0xFFFF. A start to one of them raises `fast_sel` in the same cycle and keeps `cpu_ready` high. It produces no `pb_rd` or `pb_wr`. `fast_idx` is the word address minus 0x1000 for the first range, and minus 0x4000 for the other two.
- R3: In a read, the first three busy cycles drive `pb_addr` = {word address, 1} with `pb_rd` high. The byte seen there in the third cycle is latched. The last two busy cycles drive {word address, 0} with `pb_rd` high.
- R4: A split read returns {even byte, odd byte} on `cpu_rdata` bits [15:8] and [7:0]. The result is valid when `cpu_ready` rises and stays unchanged while the bridge is idle.
- R5: In a write, `pb_wr` is high only in busy cycles 1 and 4. Cycle 1 writes `cpu_wdata[7:0]` to the odd address. Cycle 4 writes `cpu_wdata[15:8]` to the even address.
- R6: `cpu_dir_in` = 1 selects read and 0 selects write, sampled with `cpu_start`. On the fast path, `fast_we` is the inverse of `cpu_dir_in`. `fast_wdata` equals `cpu_wdata`, and `cpu_rdata` returns `fast_rdata` in the same cycle.
- R7: A `cpu_start` while `cpu_ready` is low is ignored. It raises no `fast_sel` and does not change `pb_addr`. The running sequence keeps its timing.
- R8: After reset, `cpu_ready` is high, `pb_rd` and `pb_wr` are low, and `cpu_rdata` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_start | input | 1 | Access start strobe from the CPU |
| cpu_waddr | input | 15 | CPU word address (byte address bits 15:1) |
| cpu_dir_in | input | 1 | Bus direction: 1 read, 0 write |
| cpu_wdata | input | 16 | CPU write word |
| cpu_rdata | output | 16 | Read word returned to the CPU |
| cpu_ready | output | 1 | High when the CPU may proceed |
| pb_addr | output | 16 | Byte address on the peripheral bus |
| pb_rd | output | 1 | Peripheral byte read strobe |
| pb_wr | output | 1 | Peripheral byte write strobe |
| pb_wdata | output | 8 | Peripheral write byte |
| pb_rdata | input | 8 | Peripheral read byte |
| fast_sel | output | 1 | Fast RAM select |
| fast_we | output | 1 | Fast RAM write enable |
| fast_idx | output | 14 | Fast RAM word index |
| fast_wdata | output | 16 | Fast RAM write word |
| fast_rdata | input | 16 | Fast RAM read word |

## Verification
The hardest case to reach is a second start strobe that arrives in the middle of a running split sequence. That strobe must leave the running sequence and the address unchanged. The stimulus raises `cpu_start` in the second busy cycle with a different address that falls in a fast range. The bench then checks that `fast_sel` stays low, that the byte addresses follow the first access, and that READY still returns in the sixth cycle. The range boundaries also get direct stimulus on both sides, at 0x1FFE/0x2000, 0x3FFE, 0x9FFE/0xA000, 0xC000 and 0xFFFE.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

    localparam int unsigned WADDR_W = 15;
    localparam int unsigned WORD_W  = 16;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned IDX_W   = 14;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;

    typedef struct packed {
        dir_e              dir;
        logic [BYTE_W-1:0] hold;   // odd byte on read, high byte on write
        logic [BYTE_W-1:0] even;   // even byte captured on read
        logic [BYTE_W-1:0] low;    // low write byte for the first cycle
    } lane_t;

    // Word address lies in a fast 16-bit RAM region
    function automatic logic in_fast(input logic [WADDR_W-1:0] w);
        return (w[14:12] == 3'b001) || (w[14:12] == 3'b101) || (w[14:13] == 2'b11);
    endfunction

    // Word index into the fast RAM
    function automatic logic [IDX_W-1:0] fast_index(input logic [WADDR_W-1:0] w);
        logic [WADDR_W-1:0] base;
        logic [WADDR_W-1:0] diff;
        base = (w[14:12] == 3'b001) ? 15'h1000 : 15'h4000;
        diff = w - base;
        return diff[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/wbb_region_dec.sv
module wbb_region_dec
    import wbb_pkg::*;
#(
    parameter bit FAST_EN = 1'b1
) (
    input  logic [WADDR_W-1:0] waddr,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);

    generate
        if (FAST_EN) begin : g_fast
            always_comb begin
                hit = in_fast(waddr);
                idx = fast_index(waddr);
            end
        end else begin : g_nofast
            logic unused_w;
            always_comb begin
                unused_w = ^waddr;
                hit      = 1'b0;
                idx      = '0;
            end
        end
    endgenerate

endmodule

// File: rtl/wbb_wait_ctr.sv
module wbb_wait_ctr #(
    parameter  int unsigned LOAD = 5,
    localparam int unsigned CW   = $clog2(LOAD + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    output logic [CW-1:0] cnt,
    output logic          idle
);

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= CW'(LOAD);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign idle = (cnt == '0);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> (cnt == CW'($past(cnt) - 1'b1))); // R1

endmodule

// File: rtl/wbb_byte_path.sv
module wbb_byte_path
    import wbb_pkg::*;
#(
    parameter  int unsigned LOAD    = 5,
    parameter  int unsigned EVEN_AT = 2,
    localparam int unsigned CW      = $clog2(LOAD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  dir_e              acc_dir,
    input  logic [WORD_W-1:0] acc_wdata,
    input  logic [CW-1:0]     cnt,
    input  logic [BYTE_W-1:0] pb_rdata,
    output logic              odd_phase,
    output logic              pb_rd,
    output logic              pb_wr,
    output logic [BYTE_W-1:0] pb_wdata,
    output logic [WORD_W-1:0] rd_word
);

    localparam logic [CW-1:0] C_LOAD = CW'(LOAD);
    localparam logic [CW-1:0] C_EVEN = CW'(EVEN_AT);
    localparam logic [CW-1:0] C_GRAB = CW'(EVEN_AT + 1);

    lane_t ln;

    always_ff @(posedge clk) begin
        if (rst) begin
            ln <= '{dir: DIR_READ, hold: '0, even: '0, low: '0};
        end else if (accept) begin
            ln.dir <= acc_dir;
            if (acc_dir == DIR_WRITE) begin
                ln.hold <= acc_wdata[WORD_W-1:BYTE_W];
                ln.low  <= acc_wdata[BYTE_W-1:0];
            end
        end else if (ln.dir == DIR_READ) begin
            if (cnt == C_GRAB)             ln.hold <= pb_rdata;
            if (cnt == CW'(1))             ln.even <= pb_rdata;
        end
    end

    always_comb begin
        odd_phase = (cnt > C_EVEN);
        pb_rd     = (ln.dir == DIR_READ)  && (cnt != '0);
        pb_wr     = (ln.dir == DIR_WRITE) && ((cnt == C_LOAD) || (cnt == C_EVEN));
        pb_wdata  = (cnt == C_LOAD) ? ln.low : ln.hold;
        rd_word   = {ln.even, ln.hold};
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(pb_rd && pb_wr)); // R5

    AST_ODD_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (pb_rd && $past(pb_rd) && !odd_phase && $past(odd_phase))
        |-> (rd_word[BYTE_W-1:0] == $past(pb_rdata))); // R3

endmodule

// File: rtl/word_byte_bridge.sv
module word_byte_bridge
    import wbb_pkg::*;
#(
    parameter int unsigned WAIT_LOAD = 5,
    parameter int unsigned EVEN_AT   = 2,
    parameter bit          FAST_EN   = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_start,
    input  logic [WADDR_W-1:0] cpu_waddr,
    input  logic               cpu_dir_in,
    input  logic [WORD_W-1:0]  cpu_wdata,
    output logic [WORD_W-1:0]  cpu_rdata,
    output logic               cpu_ready,
    output logic [WADDR_W:0]   pb_addr,
    output logic               pb_rd,
    output logic               pb_wr,
    output logic [BYTE_W-1:0]  pb_wdata,
    input  logic [BYTE_W-1:0]  pb_rdata,
    output logic               fast_sel,
    output logic               fast_we,
    output logic [IDX_W-1:0]   fast_idx,
    output logic [WORD_W-1:0]  fast_wdata,
    input  logic [WORD_W-1:0]  fast_rdata
);

    localparam int unsigned CW = $clog2(WAIT_LOAD + 1);

    logic               hit;
    logic               idle;
    logic               accept;
    logic               odd_phase;
    logic [CW-1:0]      cnt;
    logic [WORD_W-1:0]  rd_word;
    logic [WADDR_W-1:0] waddr_q;

    wbb_region_dec #(.FAST_EN(FAST_EN)) u_dec (
        .waddr (cpu_waddr),
        .hit   (hit),
        .idx   (fast_idx)
    );

    assign accept   = cpu_start && idle && !hit;
    assign fast_sel = cpu_start && idle && hit;

    wbb_wait_ctr #(.LOAD(WAIT_LOAD)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .cnt  (cnt),
        .idle (idle)
    );

    always_ff @(posedge clk) begin
        if (rst)         waddr_q <= '0;
        else if (accept) waddr_q <= cpu_waddr;
    end

    wbb_byte_path #(.LOAD(WAIT_LOAD), .EVEN_AT(EVEN_AT)) u_path (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .acc_dir   (dir_e'(cpu_dir_in)),
        .acc_wdata (cpu_wdata),
        .cnt       (cnt),
        .pb_rdata  (pb_rdata),
        .odd_phase (odd_phase),
        .pb_rd     (pb_rd),
        .pb_wr     (pb_wr),
        .pb_wdata  (pb_wdata),
        .rd_word   (rd_word)
    );

    always_comb begin
        cpu_ready  = idle;
        pb_addr    = {waddr_q, odd_phase};
        fast_we    = fast_sel && (dir_e'(cpu_dir_in) == DIR_WRITE);
        fast_wdata = cpu_wdata;
        cpu_rdata  = fast_sel ? fast_rdata : rd_word;
    end

    AST_STALL_ON_SPLIT: assert property (@(posedge clk) disable iff (rst)
        accept |=> !cpu_ready); // R1

    AST_FAST_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        fast_sel |=> cpu_ready); // R2

    AST_FAST_NO_BYTES: assert property (@(posedge clk) disable iff (rst)
        fast_sel |-> (!pb_rd && !pb_wr)); // R2

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!cpu_ready && !$past(cpu_ready)) |-> $stable(pb_addr[WADDR_W:1])); // R7

endmodule

// File: tb/word_byte_bridge_test.sv
module word_byte_bridge_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_start = 1'b0;
    logic [14:0] cpu_waddr = '0;
    logic        cpu_dir_in = 1'b1;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic [15:0] pb_addr;
    logic        pb_rd, pb_wr;
    logic [7:0]  pb_wdata, pb_rdata;
    logic        fast_sel, fast_we;
    logic [13:0] fast_idx;
    logic [15:0] fast_wdata, fast_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct packed { logic [15:0] a; logic [7:0] d; } bw_t;
    bw_t exp_q[$];

    always #2 clk = ~clk;

    function automatic logic [7:0] pf(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    assign pb_rdata   = pf(pb_addr);
    assign fast_rdata = {2'b01, fast_idx};

    word_byte_bridge uut (
        .clk(clk), .rst(rst), .cpu_start(cpu_start), .cpu_waddr(cpu_waddr),
        .cpu_dir_in(cpu_dir_in), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .pb_addr(pb_addr), .pb_rd(pb_rd), .pb_wr(pb_wr),
        .pb_wdata(pb_wdata), .pb_rdata(pb_rdata), .fast_sel(fast_sel),
        .fast_we(fast_we), .fast_idx(fast_idx), .fast_wdata(fast_wdata),
        .fast_rdata(fast_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // scoreboard monitor for byte writes (R5)
    always @(negedge clk) begin
        if (!rst && pb_wr) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected write", {pb_addr, 8'h00, pb_wdata}, 32'h0);
            end else begin
                bw_t e;
                e = exp_q.pop_front();
                chk({pb_addr, pb_wdata} == {e.a, e.d}, "R5 write byte", {8'h0, pb_addr, pb_wdata}, {8'h0, e.a, e.d});
            end
        end
    end

    task automatic run_split(input logic [15:0] ba, input bit rd, input logic [15:0] wd, input bit poke);
        logic [15:0] odd_a, even_a;
        odd_a  = {ba[15:1], 1'b1};
        even_a = {ba[15:1], 1'b0};
        @(negedge clk);
        cpu_start = 1'b1; cpu_waddr = ba[15:1]; cpu_dir_in = rd; cpu_wdata = wd;
        if (!rd) begin
            exp_q.push_back('{a: odd_a,  d: wd[7:0]});
            exp_q.push_back('{a: even_a, d: wd[15:8]});
        end
        #1 chk(fast_sel == 1'b0, "R2 no fast select outside ranges", fast_sel, 0);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k == 1 || k == 3) begin cpu_start = 1'b0; cpu_waddr = ba[15:1]; end
            if (k <= 5) begin
                chk(cpu_ready == 1'b0, "R1 ready low while busy", cpu_ready, 0);
                chk(pb_addr == ((k <= 3) ? odd_a : even_a), rd ? "R3 read address order" : "R5 write address order",
                    pb_addr, (k <= 3) ? odd_a : even_a);
                if (rd) chk(pb_rd == 1'b1, "R3 read strobe", pb_rd, 1);
                else    chk(pb_wr == ((k == 1) || (k == 4)), "R5 write strobe cycle", pb_wr, (k == 1) || (k == 4));
                if (poke && k == 2) begin
                    cpu_start = 1'b1; cpu_waddr = 15'h5000; // lands in a fast range
                    #1 chk(fast_sel == 1'b0, "R7 busy start ignored", fast_sel, 0);
                end
            end else begin
                chk(cpu_ready == 1'b1, "R1 ready back in sixth cycle", cpu_ready, 1);
                if (rd) chk(cpu_rdata == {pf(even_a), pf(odd_a)}, "R4 read word", cpu_rdata, {pf(even_a), pf(odd_a)});
            end
        end
        if (rd) begin
            @(negedge clk);
            chk(cpu_rdata == {pf(even_a), pf(odd_a)}, "R4 read word held", cpu_rdata, {pf(even_a), pf(odd_a)});
        end
    endtask

    task automatic run_fast(input logic [15:0] ba, input bit rd, input logic [15:0] wd, input logic [13:0] ex);
        @(negedge clk);
        cpu_start = 1'b1; cpu_waddr = ba[15:1]; cpu_dir_in = rd; cpu_wdata = wd;
        #1;
        chk(fast_sel == 1'b1, "R2 fast select", fast_sel, 1);
        chk(fast_idx == ex, "R2 fast index", fast_idx, ex);
        chk(!pb_rd && !pb_wr, "R2 no byte strobes", {pb_rd, pb_wr}, 0);
        chk(fast_we == !rd, "R6 fast write enable", fast_we, !rd);
        if (rd) chk(cpu_rdata == {2'b01, ex}, "R6 fast read data", cpu_rdata, {2'b01, ex});
        else    chk(fast_wdata == wd, "R6 fast write data", fast_wdata, wd);
        @(negedge clk);
        cpu_start = 1'b0;
        chk(cpu_ready == 1'b1, "R2 no wait on fast access", cpu_ready, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk(cpu_ready == 1'b1, "R8 reset ready", cpu_ready, 1);
        chk(!pb_rd && !pb_wr, "R8 reset strobes", {pb_rd, pb_wr}, 0);
        chk(cpu_rdata == 16'h0, "R8 reset read word", cpu_rdata, 0);

        run_split(16'h1234, 1'b1, 16'h0000, 1'b0);
        run_split(16'h8000, 1'b1, 16'h0000, 1'b0);
        run_split(16'h1FFE, 1'b0, 16'hA55A, 1'b0);
        run_split(16'h9FFE, 1'b0, 16'h0FF0, 1'b0);
        run_split(16'h4000, 1'b1, 16'h0000, 1'b1);
        run_split(16'h0006, 1'b0, 16'h1357, 1'b0);

        run_fast(16'h2000, 1'b1, 16'h0000, 14'h0000);
        run_fast(16'h3FFE, 1'b0, 16'hBEEF, 14'h0FFF);
        run_fast(16'hA000, 1'b1, 16'h0000, 14'h1000);
        run_fast(16'hC000, 1'b0, 16'h4321, 14'h2000);
        run_fast(16'hFFFE, 1'b1, 16'h0000, 14'h3FFF);

        run_split(16'h7FFE, 1'b1, 16'h0000, 1'b0);

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule